// File: doc/BRIEF.md
# Automatic Sync Source Selector

This block picks one timing reference from a group of line interfaces that run in terminal mode. Each interface gives the block a frame pulse, nominally one every 8 kHz frame, and a flag that says the interface is fully activated. A pulse from an interface that is not activated is dropped before it reaches any logic. The block forwards the pulse of the chosen interface as the reference sync. It also reports which interface it chose, and raises a flag while that reference is live.

In automatic mode the block keeps its current reference for as long as that reference stays live. An interface is live when it is activated and its last pulse came less than one and a half frame periods ago. When the current reference goes dead, the block searches for a live interface. The search starts at the next index up and wraps around past the last index. If it finds none, it holds the old index. In manual mode a fixed interface index is taken from a configuration input. In both modes a change of reference takes effect only on a pulse of the new interface, so every forwarded pulse is one whole source pulse.

The number of interfaces is a parameter and may be 4 or 8. The frame length in system clocks is also a parameter, and the loss timeout is derived from it.

Top module: `sync_src_selector`

## Requirements
- R1: After reset, selIdx is 0 and refSync and refValid are both low.
- R2: A pulse on an interface whose activeIn bit is low has no effect. It is never forwarded, and it does not make that interface live.
- R3: In automatic mode, when the current reference is not live, the replacement is the first live interface found by searching indices cur+1, cur+2 and so on, modulo NUM_IF. The change is committed in the cycle of that interface's next pulse.
- R4: refSync goes high for exactly one cycle, one clock after the selected interface (or the interface being switched to) pulses while activated. Pulses from other interfaces are not forwarded.
- R5: An activated interface stays live for TIMEOUT = FRAME_CYC*3/2 clocks after its last pulse, and then it is lost.
- R6: In automatic mode, selIdx does not change while the current reference is live, even when other interfaces are live.
- R7: In automatic mode with no live interface, refValid is low and selIdx keeps its last value.
- R8: In manual mode, the target is manualIdx. selIdx moves to it only on a pulse of that interface, and the block never switches on its own.
- R9: refValid is high only while the selected interface is live and no switch is pending.
- R10: Clearing activeIn of the selected interface drops refValid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncPulseIn | input | NUM_IF | One-cycle frame pulse per interface |
| activeIn | input | NUM_IF | Interface fully activated, per interface |
| autoMode | input | 1 | 1 = automatic selection, 0 = manual |
| manualIdx | input | $clog2(NUM_IF) | Interface index used in manual mode |
| selIdx | output | $clog2(NUM_IF) | Index of the current reference |
| refSync | output | 1 | Forwarded reference pulse |
| refValid | output | 1 | Current reference is live and no switch is pending |

## Verification
The hardest case to reach is a wrap-around hunt. The reference has to go dead while a live interface sits only below it in index, and another live interface sits above it. The bench builds this case from its ports alone. It gives each interface its own pulse schedule and lets chosen interfaces fall silent beyond the timeout while the others keep pulsing. The first switch must then go to the higher index, and a later loss must wrap past the top index to the lower one. Both cases check the pending window, where refValid is low and selIdx has not yet moved.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;
  localparam int MAX_IDX_W = 3;

  // Control to datapath: commit a switch and name the source to forward.
  typedef struct packed {
    logic                 commit;
    logic [MAX_IDX_W-1:0] fwdIdx;
  } selStrobe_t;
endpackage

// File: rtl/sync_src_monitor.sv
module sync_src_monitor
  import sync_sel_pkg::*;
#(
  parameter int NUM_IF  = 8,
  parameter int IDX_W   = 3,
  parameter int TIMEOUT = 60,
  parameter int TMR_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IF-1:0] pulseIn,
  input  logic [NUM_IF-1:0] activeIn,
  input  logic [IDX_W-1:0]  curIdx,
  input  selStrobe_t        strobe,
  output logic [NUM_IF-1:0] aliveVec,
  output logic [NUM_IF-1:0] gatedVec,
  output logic [IDX_W-1:0]  candIdx,
  output logic              candFound,
  output logic              refSync
);
  localparam logic [TMR_W-1:0] TMAX = TMR_W'(TIMEOUT);

  assign gatedVec = pulseIn & activeIn;

  for (genvar i = 0; i < NUM_IF; i++) begin : gTimer
    logic [TMR_W-1:0] silence;
    always_ff @(posedge clk) begin
      if (!rstN)             silence <= TMAX;
      else if (!activeIn[i]) silence <= TMAX;
      else if (gatedVec[i])  silence <= '0;
      else if (silence != TMAX) silence <= silence + 1'b1;
    end
    assign aliveVec[i] = activeIn[i] && (silence != TMAX);

    // R5
    silence_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      silence <= TMAX);
  end

  // Rotating search starting after the current index
  logic [IDX_W-1:0] probe;
  always_comb begin
    candFound = 1'b0;
    candIdx   = curIdx;
    probe     = '0;
    for (int k = 1; k < NUM_IF; k++) begin
      probe = curIdx + IDX_W'(k);
      if (!candFound && aliveVec[probe]) begin
        candFound = 1'b1;
        candIdx   = probe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) refSync <= 1'b0;
    else       refSync <= gatedVec[strobe.fwdIdx[IDX_W-1:0]];
  end

  // R4
  commit_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.commit) |-> refSync);

  // R2
  gated_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    refSync |-> $past(|(pulseIn & activeIn)));
endmodule

// File: rtl/sync_sel_ctrl.sv
module sync_sel_ctrl
  import sync_sel_pkg::*;
#(
  parameter int NUM_IF = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoMode,
  input  logic [IDX_W-1:0]  manualIdx,
  input  logic [NUM_IF-1:0] aliveVec,
  input  logic [NUM_IF-1:0] gatedVec,
  input  logic [IDX_W-1:0]  candIdx,
  input  logic              candFound,
  output logic [IDX_W-1:0]  curIdx,
  output logic              refValid,
  output selStrobe_t        strobe
);
  logic [IDX_W-1:0] targetIdx;
  logic [IDX_W-1:0] curNext;
  logic             commit;

  always_comb begin
    if (!autoMode)              targetIdx = manualIdx;
    else if (aliveVec[curIdx])  targetIdx = curIdx;
    else if (candFound)         targetIdx = candIdx;
    else                        targetIdx = curIdx;
  end

  // A switch lands only on a pulse of the new source
  assign commit  = (targetIdx != curIdx) && gatedVec[targetIdx];
  assign curNext = commit ? targetIdx : curIdx;

  assign strobe.commit = commit;
  assign strobe.fwdIdx = MAX_IDX_W'(curNext);

  assign refValid = aliveVec[curIdx] && (targetIdx == curIdx);

  always_ff @(posedge clk) begin
    if (!rstN) curIdx <= '0;
    else       curIdx <= curNext;
  end

  // R6
  sticky_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && aliveVec[curIdx]) |=> $stable(curIdx));

  // R7
  hold_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !aliveVec[curIdx] && !candFound) |=> $stable(curIdx));

  // R8
  manual_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!autoMode) && !$stable(curIdx)) |-> (curIdx == $past(manualIdx)));
endmodule

// File: rtl/sync_src_selector.sv
module sync_src_selector
  import sync_sel_pkg::*;
#(
  parameter int NUM_IF    = 8,
  parameter int FRAME_CYC = 25000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IF-1:0]         syncPulseIn,
  input  logic [NUM_IF-1:0]         activeIn,
  input  logic                      autoMode,
  input  logic [$clog2(NUM_IF)-1:0] manualIdx,
  output logic [$clog2(NUM_IF)-1:0] selIdx,
  output logic                      refSync,
  output logic                      refValid
);
  localparam int IDX_W   = $clog2(NUM_IF);
  localparam int TIMEOUT = (FRAME_CYC * 3) / 2;
  localparam int TMR_W   = $clog2(TIMEOUT + 1);

  initial begin
    if (NUM_IF != 4 && NUM_IF != 8) $error("NUM_IF must be 4 or 8");
  end

  logic [NUM_IF-1:0] aliveVec;
  logic [NUM_IF-1:0] gatedVec;
  logic [IDX_W-1:0]  candIdx;
  logic              candFound;
  selStrobe_t        strobe;

  sync_src_monitor #(
    .NUM_IF(NUM_IF), .IDX_W(IDX_W), .TIMEOUT(TIMEOUT), .TMR_W(TMR_W)
  ) uMon (
    .clk(clk), .rstN(rstN), .pulseIn(syncPulseIn), .activeIn(activeIn),
    .curIdx(selIdx), .strobe(strobe), .aliveVec(aliveVec),
    .gatedVec(gatedVec), .candIdx(candIdx), .candFound(candFound),
    .refSync(refSync)
  );

  sync_sel_ctrl #(.NUM_IF(NUM_IF), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .manualIdx(manualIdx),
    .aliveVec(aliveVec), .gatedVec(gatedVec), .candIdx(candIdx),
    .candFound(candFound), .curIdx(selIdx), .refValid(refValid),
    .strobe(strobe)
  );

  // R10
  valid_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> activeIn[selIdx]);
endmodule

// File: tb/sim_sync_src_selector.sv
`timescale 1ns/1ps
module sim_sync_src_selector;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  syncPulseIn;
  logic [N-1:0]  activeIn;
  logic          autoMode;
  logic [IW-1:0] manualIdx;
  logic [IW-1:0] selIdx;
  logic          refSync;
  logic          refValid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sync_src_selector #(.NUM_IF(N), .FRAME_CYC(40)) u0 (
    .clk(clk), .rstN(rstN), .syncPulseIn(syncPulseIn), .activeIn(activeIn),
    .autoMode(autoMode), .manualIdx(manualIdx), .selIdx(selIdx),
    .refSync(refSync), .refValid(refValid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a one-cycle pulse; returns at the negedge after the capturing edge
  task automatic pulse(input logic [N-1:0] m);
    syncPulseIn = m;
    @(negedge clk);
    syncPulseIn = '0;
  endtask

  task automatic t_reset();
    chk("R1", "selIdx", selIdx, 0);
    chk("R1", "refSync", refSync, 0);
    chk("R1", "refValid", refValid, 0);
  endtask

  task automatic t_inactive();
    pulse(8'h01);
    chk("R2", "refSync inactive", refSync, 0);
    chk("R2", "refValid inactive", refValid, 0);
  endtask

  task automatic t_basic();
    activeIn = 8'h09;
    step(1);
    pulse(8'h09);
    chk("R4", "refSync forwarded", refSync, 1);
    chk("R4", "selIdx", selIdx, 0);
    chk("R9", "refValid live", refValid, 1);
    step(1);
    chk("R4", "refSync one cycle", refSync, 0);
  endtask

  // iface 3 keeps pulsing, iface 0 falls silent
  task automatic t_loss();
    step(19);
    pulse(8'h08);
    chk("R4", "other source not forwarded", refSync, 0);
    chk("R6", "sticky selIdx", selIdx, 0);
    step(30);
    chk("R5", "still live before timeout", refValid, 1);
    step(15);
    chk("R9", "pending switch refValid", refValid, 0);
    chk("R3", "held until pulse", selIdx, 0);
    pulse(8'h08);
    chk("R3", "switched to 3", selIdx, 3);
    chk("R3", "switch pulse forwarded", refSync, 1);
    chk("R9", "refValid after switch", refValid, 1);
  endtask

  task automatic t_rotate();
    activeIn = 8'h4B;
    step(1);
    pulse(8'h4A);
    step(29);
    pulse(8'h42);
    chk("R6", "sticky with others live", selIdx, 3);
    step(35);
    chk("R5", "lost after timeout", refValid, 0);
    pulse(8'h42);
    chk("R3", "search picks next up (6)", selIdx, 6);
    step(29);
    pulse(8'h02);
    step(35);
    chk("R3", "pending before wrap", selIdx, 6);
    pulse(8'h02);
    chk("R3", "wrap to 1", selIdx, 1);
    chk("R4", "wrap pulse forwarded", refSync, 1);
  endtask

  task automatic t_deactivate();
    activeIn = 8'h49;
    step(1);
    chk("R10", "refValid on deactivation", refValid, 0);
    pulse(8'h02);
    chk("R2", "inactive pulse dropped", refSync, 0);
    step(70);
    chk("R7", "no live: refValid", refValid, 0);
    chk("R7", "no live: index held", selIdx, 1);
  endtask

  task automatic t_manual();
    activeIn  = 8'h09;
    autoMode  = 1'b0;
    manualIdx = 3'd5;
    step(1);
    pulse(8'h09);
    chk("R8", "manual inactive target: hold", selIdx, 1);
    chk("R8", "manual no forward", refSync, 0);
    manualIdx = 3'd3;
    step(1);
    pulse(8'h09);
    chk("R8", "manual switch to 3", selIdx, 3);
    chk("R8", "manual pulse forwarded", refSync, 1);
    step(30);
    pulse(8'h01);
    step(35);
    chk("R8", "no auto switch in manual", selIdx, 3);
    chk("R9", "manual lost refValid", refValid, 0);
    pulse(8'h01);
    chk("R8", "still no auto switch", selIdx, 3);
    autoMode = 1'b1;
    step(1);
    pulse(8'h01);
    chk("R3", "auto resumes, wraps to 0", selIdx, 0);
    chk("R9", "refValid after resume", refValid, 1);
  endtask

  initial begin
    rstN        = 1'b0;
    syncPulseIn = '0;
    activeIn    = '0;
    autoMode    = 1'b1;
    manualIdx   = '0;
    step(5);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_inactive();
    t_basic();
    t_loss();
    t_rotate();
    t_deactivate();
    t_manual();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule